// File: doc/BRIEF.md
# Configurable Three-Mode Look-Up Logic Cell

This block is a single programmable logic cell. It holds a 32-bit truth table, a two-bit partitioning mode and a set of input-selection fields. It computes two combinational results, `fn0_out` and `fn1_out`, from a five-bit general input bus and from two feedback flip-flops, `fb0` and `fb1`, that live inside the cell. The mode sets how the table is split. It can act as two independent 4-input functions, as one 5-input function, or as two 4-input functions with a runtime choice between them. In every mode the cell constrains which inputs may reach which address bit of each half-table.

The configuration is loaded serially through `cfg_din`, one bit per clock while `cfg_clk_en` is high. During loading both feedback flip-flops are held cleared. Each flip-flop has a configurable source, either `fn0_out` or `fn1_out`, and captures it on a rising clock edge when `ce` is high. Any selection field that names a feedback input therefore reads the registered result of an earlier cycle.

Top module: `lcell_top`

## Requirements
- R1: While `rst_n` is low, the configuration word, `fb0` and `fb1` are all zero, so both `fn0_out` and `fn1_out` read 0.
- R2: The cell is in dual mode when mode is 2'b00 or 2'b11. The low half (table bits 15:0) is addressed as {X3, S2, S1, cell_in[0]} and drives `fn0_out`. The high half (bits 31:16) is addressed the same way with its own fields and drives `fn1_out`. S1 and S2 come from the half's two pair codes, where 0=cell_in[1], 1=cell_in[2], 2=fb0 and 3=fb1. X3 comes from the half's fourth-input bit, where 0=cell_in[3] and 1=cell_in[4].
- R3: The cell is in wide mode when mode is 2'b01. Both halves use the low-half pair codes with X3=cell_in[3]. The value cell_in[4] chooses the high half (1) or the low half (0), which gives one function of five variables.
- R4: In wide and muxed modes, `fn0_out` and `fn1_out` carry the same selected result.
- R5: The cell is in muxed mode when mode is 2'b10. Each half uses its own pair codes with X3=cell_in[3], and cell_in[4] picks the high half (1) or the low half (0). The two halves may therefore read different feedback or input pairs.
- R6: On a rising clock edge with `ce` high and no load in progress, `fb0` takes `fn1_out` if its source bit is 1 and `fn0_out` if it is 0. `fb1` follows the same rule with its own source bit. With `ce` low, both hold their values.
- R7: At each rising edge with `cfg_clk_en` high, `fb0` and `fb1` are cleared, and `ce` has no effect.
- R8: At each rising edge with `cfg_clk_en` high, the 46-bit configuration word shifts left by one and takes `cfg_din` into bit 0, so the first bit sent ends up in bit 45. The field layout is: table 45:14, mode 13:12, low pair codes 11:10 and 9:8, high pair codes 7:6 and 5:4, low fourth-input bit 3, high fourth-input bit 2, `fb0` source 1, `fb1` source 0. With `cfg_clk_en` low, the word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_en | input | 1 | Serial configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, first bit ends in MSB |
| ce | input | 1 | Feedback flip-flop capture enable |
| cell_in | input | 5 | General inputs; bit 0 shared, bits 1-2 pair candidates, bit 3 fourth input, bit 4 alternate fourth input / selector |
| fn0_out | output | 1 | First combinational result |
| fn1_out | output | 1 | Second combinational result |
| fb0 | output | 1 | First feedback flip-flop |
| fb1 | output | 1 | Second feedback flip-flop |

## Verification
The assertions assume that `rst_n` is released away from a clock edge. They also assume that `cell_in`, `ce` and the configuration inputs are steady around each rising edge, so the results the flip-flops capture match those seen just before the edge. The stimulus changes every input only on the falling edge and takes reset low only between edges. Each mode gets random tables and selection codes, and a further muxed-mode pattern sends the feedback pair to one half and the plain inputs to the other. Loads are also made with `ce` held high, which checks that loading overrides capture.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int SUB_INPUTS = 4;
  localparam int SUB_BITS   = 1 << SUB_INPUTS;
  localparam int TBL_BITS   = 2 * SUB_BITS;
  localparam int PAIR_W     = 2;
  localparam int IN_W       = 5;

  typedef enum logic [1:0] {
    MODE_DUAL     = 2'b00,
    MODE_WIDE     = 2'b01,
    MODE_MUXED    = 2'b10,
    MODE_DUAL_ALT = 2'b11
  } lcModeT;

  typedef struct packed {
    logic [TBL_BITS-1:0] tbl;
    lcModeT              mode;
    logic [PAIR_W-1:0]   loSel1;
    logic [PAIR_W-1:0]   loSel2;
    logic [PAIR_W-1:0]   hiSel1;
    logic [PAIR_W-1:0]   hiSel2;
    logic                loFourth;
    logic                hiFourth;
    logic                fb0Src;
    logic                fb1Src;
  } lcCfgT;

  localparam int CFG_BITS = $bits(lcCfgT);

  typedef struct packed {
    logic clearFb;
    logic captureFb;
  } lcStrobeT;

  function automatic logic pickPair(input logic [PAIR_W-1:0] code,
                                    input logic candA, input logic candB,
                                    input logic fbA, input logic fbB);
    case (code)
      2'd0:    return candA;
      2'd1:    return candB;
      2'd2:    return fbA;
      default: return fbB;
    endcase
  endfunction
endpackage

// File: rtl/lcell_ctrl.sv
module lcell_ctrl
  import lcell_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgEn,
  input  logic     cfgDin,
  input  logic     capEn,
  output lcCfgT    cfg,
  output lcStrobeT strobe
);
  logic [CFG_BITS-1:0] cfgWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgWord <= '0;
    else if (cfgEn) cfgWord <= {cfgWord[CFG_BITS-2:0], cfgDin};
  end

  assign cfg              = lcCfgT'(cfgWord);
  assign strobe.clearFb   = cfgEn;
  assign strobe.captureFb = capEn && !cfgEn;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> (cfgWord[0] == $past(cfgDin)) &&
              (cfgWord[CFG_BITS-1:1] == $past(cfgWord[CFG_BITS-2:0]))); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> $stable(cfgWord)); // R8
endmodule

// File: rtl/lcell_dp.sv
module lcell_dp
  import lcell_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  lcCfgT           cfg,
  input  lcStrobeT        strobe,
  input  logic [IN_W-1:0] cellIn,
  output logic            fn0,
  output logic            fn1,
  output logic            fbA,
  output logic            fbB
);
  logic       isDual;
  logic [1:0] halfVal;
  logic       muxVal;

  assign isDual = (cfg.mode == MODE_DUAL) || (cfg.mode == MODE_DUAL_ALT);

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [PAIR_W-1:0]     s1;
    logic [PAIR_W-1:0]     s2;
    logic                  fourth;
    logic                  x3;
    logic [SUB_INPUTS-1:0] addr;
    logic [SUB_BITS-1:0]   tblHalf;

    always_comb begin
      if (h == 0 || cfg.mode == MODE_WIDE) begin
        s1 = cfg.loSel1;
        s2 = cfg.loSel2;
        fourth = cfg.loFourth;
      end else begin
        s1 = cfg.hiSel1;
        s2 = cfg.hiSel2;
        fourth = cfg.hiFourth;
      end
      x3   = isDual ? (fourth ? cellIn[4] : cellIn[3]) : cellIn[3];
      addr = {x3,
              pickPair(s2, cellIn[1], cellIn[2], fbA, fbB),
              pickPair(s1, cellIn[1], cellIn[2], fbA, fbB),
              cellIn[0]};
    end

    assign tblHalf    = cfg.tbl[h*SUB_BITS +: SUB_BITS];
    assign halfVal[h] = tblHalf[addr];
  end

  assign muxVal = cellIn[4] ? halfVal[1] : halfVal[0];
  assign fn0    = isDual ? halfVal[0] : muxVal;
  assign fn1    = isDual ? halfVal[1] : muxVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fbA <= 1'b0;
      fbB <= 1'b0;
    end else if (strobe.clearFb) begin
      fbA <= 1'b0;
      fbB <= 1'b0;
    end else if (strobe.captureFb) begin
      fbA <= cfg.fb0Src ? fn1 : fn0;
      fbB <= cfg.fb1Src ? fn1 : fn0;
    end
  end

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearFb |=> (!fbA && !fbB)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clearFb && !strobe.captureFb) |=> ($stable(fbA) && $stable(fbB))); // R6
  AST_CAPTURE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureFb |=> (fbA == $past(cfg.fb0Src ? fn1 : fn0)) &&
                         (fbB == $past(cfg.fb1Src ? fn1 : fn0))); // R6
  AST_SINGLE_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == MODE_WIDE || cfg.mode == MODE_MUXED) |-> (fn0 == fn1)); // R4
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_clk_en,
  input  logic            cfg_din,
  input  logic            ce,
  input  logic [IN_W-1:0] cell_in,
  output logic            fn0_out,
  output logic            fn1_out,
  output logic            fb0,
  output logic            fb1
);
  lcCfgT    cfg;
  lcStrobeT strobe;

  lcell_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rst_n),
    .cfgEn  (cfg_clk_en),
    .cfgDin (cfg_din),
    .capEn  (ce),
    .cfg    (cfg),
    .strobe (strobe)
  );

  lcell_dp i_dp (
    .clk    (clk),
    .rstN   (rst_n),
    .cfg    (cfg),
    .strobe (strobe),
    .cellIn (cell_in),
    .fn0    (fn0_out),
    .fn1    (fn1_out),
    .fbA    (fb0),
    .fbB    (fb1)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (!fb0 && !fb1 && !fn0_out && !fn1_out)); // R1
endmodule

// File: tb/test_lcell_top.sv
`timescale 1ns/1ps
module test_lcell_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_clk_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic       ce = 1'b0;
  logic [4:0] cell_in = '0;
  logic       fn0_out, fn1_out, fb0, fb1;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [45:0] cfgM = '0;
  logic        fbM0 = 0, fbM1 = 0;
  bit          justLoaded = 0;

  always #2.5 clk = ~clk;

  lcell_top i_lcell_top (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  function automatic int srcOf(int code, logic [4:0] ins);
    case (code)
      0: return int'(ins[1]);
      1: return int'(ins[2]);
      2: return int'(fbM0);
      default: return int'(fbM1);
    endcase
  endfunction

  task automatic step(input bit en, input bit din, input bit ceV, input logic [4:0] ins);
    int modeI, lo1, lo2, hi1, hi2, xLo, xHi, idxLo, idxHi;
    bit dual;
    logic vLo, vHi, expF, expG;
    string tagF, tagG, tagQ;
    @(negedge clk);
    cfg_clk_en = en; cfg_din = din; ce = ceV; cell_in = ins;
    #1;
    modeI = int'(cfgM[13:12]);
    dual  = (modeI == 0) || (modeI == 3);
    lo1 = int'(cfgM[11:10]); lo2 = int'(cfgM[9:8]);
    hi1 = int'(cfgM[7:6]);   hi2 = int'(cfgM[5:4]);
    if (modeI == 1) begin hi1 = lo1; hi2 = lo2; end
    xLo = dual ? (cfgM[3] ? int'(ins[4]) : int'(ins[3])) : int'(ins[3]);
    xHi = dual ? (cfgM[2] ? int'(ins[4]) : int'(ins[3])) : int'(ins[3]);
    idxLo = int'(ins[0]) + 2*srcOf(lo1, ins) + 4*srcOf(lo2, ins) + 8*xLo;
    idxHi = int'(ins[0]) + 2*srcOf(hi1, ins) + 4*srcOf(hi2, ins) + 8*xHi;
    vLo = cfgM[14 + idxLo];
    vHi = cfgM[30 + idxHi];
    if (dual) begin expF = vLo; expG = vHi; tagF = "R2"; tagG = "R2"; end
    else begin
      expF = ins[4] ? vHi : vLo; expG = expF;
      tagF = (modeI == 1) ? "R3" : "R5"; tagG = "R4";
    end
    if (justLoaded) tagF = "R8";
    tagQ = justLoaded ? "R7" : "R6";
    chk(tagF, fn0_out, expF);
    chk(tagG, fn1_out, expG);
    chk(tagQ, fb0, fbM0);
    chk(tagQ, fb1, fbM1);
    justLoaded = en;
    if (en) begin
      cfgM = {cfgM[44:0], din};
      fbM0 = 0; fbM1 = 0;
    end else if (ceV) begin
      fbM0 = cfgM[1] ? expG : expF;
      fbM1 = cfgM[0] ? expG : expF;
    end
  endtask

  task automatic loadCfg(input logic [45:0] word, input bit ceDuring);
    for (int i = 45; i >= 0; i--) step(1'b1, word[i], ceDuring, 5'($urandom));
  endtask

  task automatic runRandom(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, ($urandom % 4) != 0, 5'($urandom));
  endtask

  function automatic logic [45:0] randCfg(input logic [1:0] mode);
    logic [45:0] w;
    w = {$urandom, 14'($urandom)};
    w[13:12] = mode;
    return w;
  endfunction

  task automatic checkReset();
    #1;
    chk("R1", fn0_out, 1'b0);
    chk("R1", fn1_out, 1'b0);
    chk("R1", fb0, 1'b0);
    chk("R1", fb1, 1'b0);
  endtask

  initial begin
    logic [45:0] w;
    repeat (3) @(negedge clk);
    checkReset();
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++) begin
      loadCfg(randCfg(2'(m)), m[0]);
      runRandom(250);
    end
    // muxed mode: low half reads plain inputs, high half reads both feedbacks
    w = randCfg(2'b10);
    w[11:10] = 2'd0; w[9:8] = 2'd1; w[7:6] = 2'd2; w[5:4] = 2'd3;
    loadCfg(w, 1'b1);
    runRandom(300);
    // dual mode with fourth input from the alternate bit on both halves
    w = randCfg(2'b00);
    w[3] = 1'b1; w[2] = 1'b1; w[7:6] = 2'd2; w[11:10] = 2'd3;
    loadCfg(w, 1'b0);
    runRandom(200);
    // reset in mid-operation clears config and feedback
    @(negedge clk);
    rst_n = 1'b0; cell_in = 5'h1f; ce = 1'b1;
    cfgM = '0; fbM0 = 0; fbM1 = 0; justLoaded = 0;
    checkReset();
    @(negedge clk);
    rst_n = 1'b1;
    runRandom(20);
    for (int k = 0; k < 6; k++) begin
      loadCfg(randCfg(2'($urandom)), 1'b1);
      runRandom(120);
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule